// File: doc/BRIEF.md
# Load Effective Address Generator

This block forms the memory address for the fixed-point load operations of a 64-bit register machine. It receives an already decoded operation: an addressing mode, an update bit, the base and target register numbers, the values read from the register file for the base and index registers, and the raw 16-bit immediate field. One clock after an input strobe it presents the address, a request to write that address back into the base register, and a flag that marks a malformed update operation.

Four addressing modes are supported. Three add an immediate to the base: the immediate as it stands, the immediate with its low two bits cleared (a 14-bit field scaled by 4), and the immediate with its low four bits cleared (a 12-bit field scaled by 16). The fourth adds the index register value. In plain forms a base register number of zero selects a literal zero base. In update forms the base is always the register value and the result goes back into the base register, unless the form is malformed.

Top module: `ldAddrGen`

## Requirements
- R1: While `rstN` is low and after reset, `outValid`, `raWrEn` and `badForm` are 0 and `effAddr` is 0 until the first accepted strobe.
- R2: Every cycle with `inValid`=1 yields `outValid`=1 on the next cycle, and a cycle without it yields `outValid`=0; `raWrEn` and `badForm` are 0 whenever `outValid` is 0.
- R3: In plain forms (`inUpdate`=0) the base is zero when `raIdx`=0 and `raValue` otherwise.
- R4: Mode 0 (`inMode`=2'd0) adds `dispField` sign-extended from bit 15 to 64 bits.
- R5: Mode 1 (`inMode`=2'd1) adds `{dispField[15:2],2'b00}` sign-extended from bit 15; `dispField[1:0]` have no effect.
- R6: Mode 2 (`inMode`=2'd2) adds `{dispField[15:4],4'b0000}` sign-extended from bit 15; `dispField[3:0]` have no effect.
- R7: Mode 3 (`inMode`=2'd3) adds `rbValue`; `dispField` has no effect.
- R8: In update forms (`inUpdate`=1) the base is `raValue` in every case, including `raIdx`=0.
- R9: An update form with `raIdx`≠0 and `raIdx`≠`rtIdx` gives `raWrEn`=1 and `raWrIdx`=`raIdx` together with the address.
- R10: An update form with `raIdx`=0 or `raIdx`=`rtIdx` gives `badForm`=1 and `raWrEn`=0; `effAddr` still carries the computed sum.
- R11: The addition wraps modulo 2^64 with no overflow indication.
- R12: Plain forms never raise `raWrEn` or `badForm`, even when `raIdx` equals `rtIdx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation strobe |
| inMode | input | 2 | Addressing mode: 0 imm, 1 imm x4, 2 imm x16, 3 indexed |
| inUpdate | input | 1 | Update form (write address back to base register) |
| raIdx | input | 5 | Base register number |
| rtIdx | input | 5 | Target register number |
| raValue | input | 64 | Base register contents |
| rbValue | input | 64 | Index register contents |
| dispField | input | 16 | Raw immediate field |
| outValid | output | 1 | Result valid, one cycle after `inValid` |
| effAddr | output | 64 | Computed address |
| raWrEn | output | 1 | Write-back request for the base register |
| raWrIdx | output | 5 | Register number for the write-back |
| badForm | output | 1 | Malformed update operation |

## Verification
The bench aims at the base-zero rule, where a design that tested the register number in update forms as well would return an address without the base, and at the low immediate bits of the scaled modes, which a design that forgot to clear them would leak into the address by a few bytes. The two malformed update cases (base number zero, base equal to target) are driven separately, since a design that caught only one would request a write-back for the other, and plain forms with equal numbers are driven to catch a flag raised without regard to the update bit. Wrap-around sums, back-to-back strobes and idle gaps check that the address is modular and that the qualifiers fall with `outValid`.

// File: rtl/ldagen_pkg.sv
package ldagen_pkg;

  localparam int XLEN      = 64;
  localparam int REG_IDX_W = 5;
  localparam int DISP_W    = 16;

  typedef enum logic [1:0] {
    MODE_DISP     = 2'd0,
    MODE_DISP_X4  = 2'd1,
    MODE_DISP_X16 = 2'd2,
    MODE_INDEX    = 2'd3
  } addrMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic      capture;
    logic      zeroBase;
    addrMode_t offSel;
    logic      wbReq;
    logic      badFlag;
  } ctlStrobes_t;

endpackage

// File: rtl/ldagen_ctrl.sv
module ldagen_ctrl
  import ldagen_pkg::*;
#(
  parameter int REG_IDX_W = ldagen_pkg::REG_IDX_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [1:0]           inMode,
  input  logic                 inUpdate,
  input  logic [REG_IDX_W-1:0] raIdx,
  input  logic [REG_IDX_W-1:0] rtIdx,
  output ctlStrobes_t          strb,
  output logic                 outValid
);

  logic raIsZero;
  logic raAliasRt;
  logic updBad;

  always_comb begin
    raIsZero  = (raIdx == '0);
    raAliasRt = (raIdx == rtIdx);
    updBad    = inUpdate && (raIsZero || raAliasRt);

    strb.capture  = inValid;
    strb.zeroBase = !inUpdate && raIsZero;
    strb.offSel   = addrMode_t'(inMode);
    strb.wbReq    = inValid && inUpdate && !updBad;
    strb.badFlag  = inValid && updBad;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

endmodule

// File: rtl/ldagen_dp.sv
module ldagen_dp
  import ldagen_pkg::*;
#(
  parameter int XLEN      = ldagen_pkg::XLEN,
  parameter int REG_IDX_W = ldagen_pkg::REG_IDX_W,
  parameter int DISP_W    = ldagen_pkg::DISP_W,
  parameter int SHIFT_X4  = 2,
  parameter int SHIFT_X16 = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobes_t          strb,
  input  logic [REG_IDX_W-1:0] raIdx,
  input  logic [XLEN-1:0]      raValue,
  input  logic [XLEN-1:0]      rbValue,
  input  logic [DISP_W-1:0]    dispField,
  output logic [XLEN-1:0]      effAddr,
  output logic                 raWrEn,
  output logic [REG_IDX_W-1:0] raWrIdx,
  output logic                 badForm
);

  localparam int NUM_MODES = 4;
  localparam int EXT_W     = XLEN - DISP_W;

  logic [XLEN-1:0] offCand [NUM_MODES];
  logic [XLEN-1:0] baseVal;
  logic [XLEN-1:0] addrSum;

  // one offset candidate per mode
  for (genvar m = 0; m < NUM_MODES; m++) begin : g_off
    if (m == int'(MODE_INDEX)) begin : g_idx
      assign offCand[m] = rbValue;
    end else begin : g_imm
      localparam int LOW = (m == int'(MODE_DISP_X4))  ? SHIFT_X4 :
                           (m == int'(MODE_DISP_X16)) ? SHIFT_X16 : 0;
      logic [DISP_W-1:0] scaled;
      if (LOW == 0) begin : g_raw
        assign scaled = dispField;
      end else begin : g_clr
        assign scaled = {dispField[DISP_W-1:LOW], {LOW{1'b0}}};
      end
      assign offCand[m] = {{EXT_W{scaled[DISP_W-1]}}, scaled};
    end
  end

  always_comb begin
    baseVal = strb.zeroBase ? '0 : raValue;
    addrSum = baseVal + offCand[strb.offSel];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      effAddr <= '0;
      raWrEn  <= 1'b0;
      raWrIdx <= '0;
      badForm <= 1'b0;
    end else if (strb.capture) begin
      effAddr <= addrSum;
      raWrEn  <= strb.wbReq;
      raWrIdx <= raIdx;
      badForm <= strb.badFlag;
    end else begin
      raWrEn  <= 1'b0;
      badForm <= 1'b0;
    end
  end

endmodule

// File: rtl/ldAddrGen.sv
module ldAddrGen
  import ldagen_pkg::*;
#(
  parameter int XLEN      = ldagen_pkg::XLEN,
  parameter int REG_IDX_W = ldagen_pkg::REG_IDX_W,
  parameter int DISP_W    = ldagen_pkg::DISP_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [1:0]           inMode,
  input  logic                 inUpdate,
  input  logic [REG_IDX_W-1:0] raIdx,
  input  logic [REG_IDX_W-1:0] rtIdx,
  input  logic [XLEN-1:0]      raValue,
  input  logic [XLEN-1:0]      rbValue,
  input  logic [DISP_W-1:0]    dispField,
  output logic                 outValid,
  output logic [XLEN-1:0]      effAddr,
  output logic                 raWrEn,
  output logic [REG_IDX_W-1:0] raWrIdx,
  output logic                 badForm
);

  ctlStrobes_t strb;

  ldagen_ctrl #(.REG_IDX_W(REG_IDX_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inMode   (inMode),
    .inUpdate (inUpdate),
    .raIdx    (raIdx),
    .rtIdx    (rtIdx),
    .strb     (strb),
    .outValid (outValid)
  );

  ldagen_dp #(
    .XLEN      (XLEN),
    .REG_IDX_W (REG_IDX_W),
    .DISP_W    (DISP_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .raIdx     (raIdx),
    .raValue   (raValue),
    .rbValue   (rbValue),
    .dispField (dispField),
    .effAddr   (effAddr),
    .raWrEn    (raWrEn),
    .raWrIdx   (raWrIdx),
    .badForm   (badForm)
  );

endmodule

// File: rtl/ldagen_chk.sv
module ldagen_chk
  import ldagen_pkg::*;
#(
  parameter int XLEN      = ldagen_pkg::XLEN,
  parameter int REG_IDX_W = ldagen_pkg::REG_IDX_W,
  parameter int DISP_W    = ldagen_pkg::DISP_W
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 inValid,
  input logic [1:0]           inMode,
  input logic                 inUpdate,
  input logic [REG_IDX_W-1:0] raIdx,
  input logic [REG_IDX_W-1:0] rtIdx,
  input logic [XLEN-1:0]      raValue,
  input logic [XLEN-1:0]      rbValue,
  input logic [DISP_W-1:0]    dispField,
  input logic                 outValid,
  input logic [XLEN-1:0]      effAddr,
  input logic                 raWrEn,
  input logic [REG_IDX_W-1:0] raWrIdx,
  input logic                 badForm
);

  assert_strobe_to_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  assert_valid_has_cause_R2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (!raWrEn && !badForm));

  assert_zero_base_R3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inUpdate && raIdx == '0 && inMode == MODE_INDEX)
    |=> effAddr == $past(rbValue));

  assert_update_base_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inUpdate && inMode == MODE_INDEX)
    |=> effAddr == $past(raValue) + $past(rbValue));

  assert_writeback_R9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inUpdate && raIdx != '0 && raIdx != rtIdx)
    |=> (raWrEn && !badForm && raWrIdx == $past(raIdx)));

  assert_bad_update_R10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inUpdate && (raIdx == '0 || raIdx == rtIdx))
    |=> (badForm && !raWrEn));

  assert_plain_no_wb_R12: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inUpdate) |=> (!raWrEn && !badForm));

endmodule

bind ldAddrGen ldagen_chk #(
  .XLEN      (XLEN),
  .REG_IDX_W (REG_IDX_W),
  .DISP_W    (DISP_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .inMode    (inMode),
  .inUpdate  (inUpdate),
  .raIdx     (raIdx),
  .rtIdx     (rtIdx),
  .raValue   (raValue),
  .rbValue   (rbValue),
  .dispField (dispField),
  .outValid  (outValid),
  .effAddr   (effAddr),
  .raWrEn    (raWrEn),
  .raWrIdx   (raWrIdx),
  .badForm   (badForm)
);

// File: tb/sim_ldAddrGen.sv
`timescale 1ns/1ps
module sim_ldAddrGen;

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [1:0]  inMode;
  logic        inUpdate;
  logic [4:0]  raIdx;
  logic [4:0]  rtIdx;
  logic [63:0] raValue;
  logic [63:0] rbValue;
  logic [15:0] dispField;
  logic        outValid;
  logic [63:0] effAddr;
  logic        raWrEn;
  logic [4:0]  raWrIdx;
  logic        badForm;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // expectation for the next sample
  bit          expValid = 0;
  logic [63:0] expAddr  = '0;
  bit          expWb    = 0;
  logic [4:0]  expIdx   = '0;
  bit          expBad   = 0;
  string       expTag   = "R2";

  always #2 clk = ~clk;

  ldAddrGen u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inMode(inMode),
    .inUpdate(inUpdate), .raIdx(raIdx), .rtIdx(rtIdx),
    .raValue(raValue), .rbValue(rbValue), .dispField(dispField),
    .outValid(outValid), .effAddr(effAddr), .raWrEn(raWrEn),
    .raWrIdx(raWrIdx), .badForm(badForm)
  );

  function automatic logic [63:0] refAddr(input logic [1:0] m, input bit upd,
      input logic [4:0] ra, input logic [63:0] rav, input logic [63:0] rbv,
      input logic [15:0] d);
    longint base;
    longint off;
    base = (!upd && ra == 5'd0) ? 64'sd0 : longint'(rav);
    case (m)
      2'd0:    off = longint'(shortint'(d));
      2'd1:    off = longint'(shortint'(d & 16'hFFFC));
      2'd2:    off = longint'(shortint'(d & 16'hFFF0));
      default: off = longint'(rbv);
    endcase
    return 64'(base + off);
  endfunction

  task automatic checkOut();
    bit bad;
    tests++;
    bad = (outValid !== expValid);
    if (expValid) begin
      bad = bad || (effAddr !== expAddr) || (raWrEn !== expWb) || (badForm !== expBad);
      if (expWb) bad = bad || (raWrIdx !== expIdx);
    end else begin
      bad = bad || (raWrEn !== 1'b0) || (badForm !== 1'b0);
    end
    if (bad) begin
      fails++;
      $display("FAIL %s: got v=%0b a=%h wb=%0b idx=%0d bad=%0b exp v=%0b a=%h wb=%0b idx=%0d bad=%0b",
               expTag, outValid, effAddr, raWrEn, raWrIdx, badForm,
               expValid, expAddr, expWb, expIdx, expBad);
    end
  endtask

  task automatic drive(input bit v, input logic [1:0] m, input bit upd,
      input logic [4:0] ra, input logic [4:0] rt, input logic [63:0] rav,
      input logic [63:0] rbv, input logic [15:0] d, input string tag);
    @(negedge clk);
    checkOut();
    inValid = v; inMode = m; inUpdate = upd; raIdx = ra; rtIdx = rt;
    raValue = rav; rbValue = rbv; dispField = d;
    expValid = v;
    expTag   = v ? tag : "R2";
    expAddr  = refAddr(m, upd, ra, rav, rbv, d);
    expWb    = v && upd && ra != 5'd0 && ra != rt;
    expBad   = v && upd && (ra == 5'd0 || ra == rt);
    expIdx   = ra;
  endtask

  task automatic idle();
    drive(0, 2'd0, 0, 5'd0, 5'd0, 64'd0, 64'd0, 16'd0, "R2");
  endtask

  initial begin
    rstN = 0; inValid = 0; inMode = 0; inUpdate = 0; raIdx = 0; rtIdx = 0;
    raValue = 0; rbValue = 0; dispField = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    tests++;
    if (outValid !== 0 || raWrEn !== 0 || badForm !== 0 || effAddr !== 64'd0) begin
      fails++;
      $display("FAIL R1: got v=%0b a=%h wb=%0b bad=%0b exp all zero",
               outValid, effAddr, raWrEn, badForm);
    end
    rstN = 1;
    idle();  // R1 check: still quiet after release
    idle();

    // R3 zero base vs register base
    drive(1, 2'd0, 0, 5'd0, 5'd2, 64'h1234, 64'h0, 16'h0010, "R3");
    drive(1, 2'd0, 0, 5'd7, 5'd2, 64'h1000, 64'h0, 16'h0010, "R3");
    // R4 negative immediate
    drive(1, 2'd0, 0, 5'd7, 5'd2, 64'h1000, 64'h0, 16'hFFF0, "R4");
    idle();
    // R5 low two bits ignored, negative scaled
    drive(1, 2'd1, 0, 5'd3, 5'd1, 64'h2000, 64'h0, 16'h0007, "R5");
    drive(1, 2'd1, 0, 5'd3, 5'd1, 64'h2000, 64'h0, 16'h8003, "R5");
    // R6 low four bits ignored
    drive(1, 2'd2, 0, 5'd3, 5'd1, 64'h4000, 64'h0, 16'h001F, "R6");
    drive(1, 2'd2, 0, 5'd3, 5'd1, 64'h4000, 64'h0, 16'hFFFF, "R6");
    // R7 indexed, immediate ignored
    drive(1, 2'd3, 0, 5'd9, 5'd1, 64'h100, 64'h0ABC, 16'h7FFF, "R7");
    drive(1, 2'd3, 0, 5'd0, 5'd1, 64'h100, 64'h0ABC, 16'h1234, "R7");
    idle();
    // R8 update uses register even when number is zero (also R10)
    drive(1, 2'd0, 1, 5'd0, 5'd3, 64'h500, 64'h0, 16'h0008, "R8");
    drive(1, 2'd3, 1, 5'd0, 5'd3, 64'h700, 64'h20, 16'h0, "R8");
    // R9 valid update
    drive(1, 2'd0, 1, 5'd4, 5'd5, 64'h3000, 64'h0, 16'h0040, "R9");
    drive(1, 2'd1, 1, 5'd31, 5'd5, 64'h3000, 64'h0, 16'hFFFC, "R9");
    // R10 base equals target
    drive(1, 2'd3, 1, 5'd6, 5'd6, 64'h800, 64'h8, 16'h0, "R10");
    idle();
    // R11 wrap
    drive(1, 2'd3, 0, 5'd1, 5'd2, 64'hFFFF_FFFF_FFFF_FFF0, 64'h20, 16'h0, "R11");
    drive(1, 2'd0, 1, 5'd1, 5'd2, 64'h0000_0000_0000_0004, 64'h0, 16'hFFF0, "R11");
    // R12 plain form with equal numbers
    drive(1, 2'd0, 0, 5'd8, 5'd8, 64'h900, 64'h0, 16'h0001, "R12");
    drive(1, 2'd2, 0, 5'd0, 5'd0, 64'h900, 64'h0, 16'h0100, "R12");
    idle();

    // mixed traffic with gaps
    for (int i = 0; i < 300; i++) begin
      bit          v;
      logic [4:0]  ra;
      logic [4:0]  rt;
      v  = ($urandom % 4) != 0;
      ra = 5'($urandom % 8);
      rt = 5'($urandom % 8);
      drive(v, 2'($urandom), 1'($urandom), ra, rt,
            {$urandom, $urandom}, {$urandom, $urandom}, 16'($urandom), "R2");
    end
    idle();
    idle();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule